// File: doc/BRIEF.md
# Reloading Countdown Timer with Source-Rate Prescaler

This block is an 8-bit countdown timer that runs on the system clock. A single-cycle tick-enable input arrives at 32.768 kHz. An internal prescaler turns that base tick into one of four slower source ticks. The counter steps down once per source tick. It ends a period when it sees a source tick while it holds 1. At that point it reloads the programmed value, raises a one-cycle event pulse and sets a sticky timer flag. A period therefore lasts n source ticks.

The host uses three registers through a plain write port and a combinational read port:

- A control register holds the run enable and the source select.
- A count register takes the start and reload value, and reads back the live count.
- A status register holds the timer flag. The host clears the flag by writing zero to it. Writing a one has no effect.

The ports carry control and status only, so there is no valid/ready handshake. A write takes effect at the clock edge on which `wr_en` is high.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control register, the count register and the status register all read 0, and `evt_o` is low.
- R2: The control register (address 0) reads back as {enable at bit 7, zeros at bits 6:2, source select at bits 1:0}. Bits 6:2 always read as 0.
- R3: The source-select value sets the source-tick period in base ticks: 0 gives DIV_FAST, 1 gives DIV_MID, 2 gives DIV_SLOW, and 3 gives DIV_SLOW*DIV_MINUTE. With the defaults these are 4096 Hz, 64 Hz, 1 Hz and 1/60 Hz from a 32.768 kHz base.
- R4: With a value n from 1 to 255 loaded, a period lasts exactly n source ticks. `evt_o` marks the end of each period. The counter reloads n, and the next period starts with no host action.
- R5: Reading the count register (address 1) returns the live count, which is n minus the number of source ticks seen so far in the current period.
- R6: Loading 0 halts the timer. The count stays 0 and no event occurs.
- R7: While the enable is 0, the count holds, the prescaler does not advance and no event occurs.
- R8: A write to the status register (address 2) is ANDed into the flags. Bit 2 holds the timer flag. Writing 0 to bit 2 clears the flag, and writing 1 leaves it unchanged. When no flag write happens, the flag stays set after an event.
- R9: When a period ends in the same cycle as a host write of 0 to the timer flag, the flag ends up set.
- R10: `evt_o` is high for exactly one cycle per period end, whether or not the flag is already set.
- R11: A write to the count register or to the control register restarts the prescaler phase. A count write also loads both the reload value and the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz base tick enable, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 count, 2 status |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Combinational read data |
| evt_o | output | 1 | One-cycle period-end pulse |

## Verification
The bench builds the timer with DIV_FAST=2, DIV_MID=4, DIV_SLOW=8 and DIV_MINUTE=3. At these values every source select produces a period within a few thousand base ticks. That makes it possible to sweep every select against several reload values, including 255, and to count each period against n times the divisor. The small divisors also let the bench line up exact collisions between a period end, a flag-clear write and a prescaler restart.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_STAT  = 2'd2;
  localparam int unsigned FLAG_BIT  = 2;
  localparam int unsigned EN_BIT    = 7;
  localparam int unsigned NUM_SRC   = 4;

  typedef enum logic [1:0] {
    SRC_FAST   = 2'd0,
    SRC_MID    = 2'd1,
    SRC_SLOW   = 2'd2,
    SRC_MINUTE = 2'd3
  } src_sel_e;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int unsigned DIV_FAST   = 8,
  parameter int unsigned DIV_MID    = 512,
  parameter int unsigned DIV_SLOW   = 32768,
  parameter int unsigned DIV_MINUTE = 60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 run_i,
  input  logic                 restart_i,
  input  cdt_pkg::src_sel_e    sel_i,
  output logic                 src_tick_o
);
  localparam int unsigned MAX_DIV = DIV_SLOW * DIV_MINUTE;
  localparam int unsigned CW      = $clog2(MAX_DIV + 1);

  logic [CW-1:0] limit [cdt_pkg::NUM_SRC];
  logic [CW-1:0] phase_q;
  logic [CW-1:0] lim_sel;
  logic          at_end;

  for (genvar s = 0; s < int'(cdt_pkg::NUM_SRC); s++) begin : g_lim
    localparam int unsigned DIVS = (s == 0) ? DIV_FAST :
                                   (s == 1) ? DIV_MID  :
                                   (s == 2) ? DIV_SLOW : MAX_DIV;
    assign limit[s] = CW'(DIVS - 1);
  end

  assign lim_sel    = limit[sel_i];
  assign at_end     = (phase_q >= lim_sel);
  assign src_tick_o = run_i && tick_i && !restart_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase_q <= '0;
    else if (restart_i)         phase_q <= '0;
    else if (run_i && tick_i)   phase_q <= at_end ? '0 : phase_q + 1'b1;
  end

  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (phase_q == '0));
  a_r7_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> (phase_q == $past(phase_q)));
endmodule

// File: rtl/cdt_countdown.sv
module cdt_countdown #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             src_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             evt_o
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             evt_q;
  logic             period_end;

  assign period_end = src_tick_i && !load_i && (count_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      evt_q    <= 1'b0;
    end else begin
      evt_q <= period_end;
      if (load_i) begin
        reload_q <= load_val_i;
        count_q  <= load_val_i;
      end else if (period_end) begin
        count_q  <= reload_q;
      end else if (src_tick_i && count_q != '0) begin
        count_q  <= count_q - 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign evt_o   = evt_q;

  a_r6_zero_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0 && !load_i) |=> (count_q == '0 && !evt_q));
  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (count_q == reload_q));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !src_tick_i) |=> $stable(count_q));
endmodule

// File: rtl/cdt_flag.sv
module cdt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (wr_i)  flag_q <= flag_q & wr_bit_i;
  end

  assign flag_o = flag_q;

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
  a_r8_no_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int unsigned DIV_FAST   = 8,
  parameter int unsigned DIV_MID    = 512,
  parameter int unsigned DIV_SLOW   = 32768,
  parameter int unsigned DIV_MINUTE = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       evt_o
);
  import cdt_pkg::*;

  localparam int unsigned CNT_W = 8;

  logic             en_q;
  src_sel_e         sel_q;
  logic             wr_ctrl, wr_cnt, wr_stat;
  logic             src_tick;
  logic [CNT_W-1:0] count;
  logic             evt;
  logic             tf;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == ADDR_COUNT);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= SRC_FAST;
    end else if (wr_ctrl) begin
      en_q  <= wr_data[EN_BIT];
      sel_q <= src_sel_e'(wr_data[1:0]);
    end
  end

  cdt_prescaler #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID),
    .DIV_SLOW(DIV_SLOW), .DIV_MINUTE(DIV_MINUTE)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(en_q),
    .restart_i(wr_cnt || wr_ctrl), .sel_i(sel_q), .src_tick_o(src_tick)
  );

  cdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(wr_cnt), .load_val_i(wr_data),
    .src_tick_i(src_tick), .count_o(count), .evt_o(evt)
  );

  cdt_flag u_tf (
    .clk(clk), .rst_n(rst_n), .set_i(src_tick && !wr_cnt && count == CNT_W'(1)),
    .wr_i(wr_stat), .wr_bit_i(wr_data[FLAG_BIT]), .flag_o(tf)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADDR_CTRL:  rd_data = {en_q, 5'b0, sel_q};
      ADDR_COUNT: rd_data = count;
      ADDR_STAT:  rd_data[FLAG_BIT] = tf;
      default:    rd_data = '0;
    endcase
  end

  assign evt_o = evt;

  a_r10_flag_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> tf);
  a_r8_rise_only_on_evt: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tf) |-> evt_o);
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_cnt) |=> (!evt_o && count == $past(count)));
endmodule

// File: tb/cdt_timer_bench.sv
module cdt_timer_bench;
  localparam int unsigned DF = 2, DM = 4, DS = 8, DN = 3;

  logic       clk = 0, rst_n = 0, tick_i = 0, wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       evt_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cdt_timer #(.DIV_FAST(DF), .DIV_MID(DM), .DIV_SLOW(DS), .DIV_MINUTE(DN)) u_cdt_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .evt_o(evt_o));

  function automatic int divof(int s);
    return (s == 0) ? DF : (s == 1) ? DM : (s == 2) ? DS : DS * DN;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  // one base tick, optional concurrent status write; returns evt after it
  task automatic tick(output logic e, input logic do_wr = 0, input logic [7:0] d = 0);
    @(negedge clk); tick_i = 1;
    if (do_wr) begin wr_en = 1; wr_addr = 2'd2; wr_data = d; end
    @(negedge clk); tick_i = 0; wr_en = 0; e = evt_o;
    @(negedge clk);
    if (e) chk("R10 pulse width", int'(evt_o), 0);
  endtask

  task automatic measure(string req, int exp);
    int n = 0;
    logic e = 0;
    while (!e && n < exp + 8) begin tick(e); n++; end
    chk(req, n, exp);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    chk("R1 evt", int'(evt_o), 0);

    wr(0, 8'hFF); rd(0, v); chk("R2 ctrl readback", v, 8'h83);
    wr(0, 8'h7E); rd(0, v); chk("R2 ctrl readback", v, 8'h02);

    // R3/R4 sweep: every select, several n, two periods each
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        int n = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 5 : ((s == 0) ? 255 : 3);
        wr(0, 8'h80 | 8'(s));
        wr(1, 8'(n));
        measure("R3 first period", n * divof(s));
        rd(1, v); chk("R4 reloaded", v, n);
        measure("R4 auto period (R10 with flag set)", n * divof(s));
      end
    end

    rd(2, v); chk("R8 flag sticky", v, 4);
    wr(2, 8'hFF); rd(2, v); chk("R8 write 1 keeps", v, 4);
    wr(2, 8'hFB); rd(2, v); chk("R8 write 0 clears", v, 0);

    // R5 live count
    wr(0, 8'h80); wr(1, 8'd10);
    repeat (3 * DF) tick(e);
    rd(1, v); chk("R5 live count", v, 7);

    // R7 disable holds
    wr(0, 8'h00);
    v = 0;
    for (int i = 0; i < 40; i++) begin tick(e); if (e) v++; end
    chk("R7 no event", v, 0);
    rd(1, v); chk("R7 count held", v, 7);

    // R6 zero halts
    wr(0, 8'h80); wr(1, 8'd0);
    v = 0;
    for (int i = 0; i < 60; i++) begin tick(e); if (e) v++; end
    chk("R6 no event", v, 0);
    rd(1, v); chk("R6 count zero", v, 0);

    // R9 set beats clear
    wr(2, 8'h00);
    wr(1, 8'd1);
    tick(e);
    tick(e, 1, 8'h00);
    chk("R9 evt", int'(e), 1);
    rd(2, v); chk("R9 flag set", v, 4);

    // R11 count write restarts prescaler phase
    wr(0, 8'h81);
    tick(e); tick(e); tick(e);
    wr(1, 8'd1);
    measure("R11 restart after count write", DM);
    tick(e); tick(e);
    wr(0, 8'h81);
    measure("R11 restart after ctrl write", DM);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule